// File: doc/BRIEF.md
# Two-Bank Byte-Addressed GPIO Port Controller

This block is a general-purpose pin controller that software reaches through a byte-wide port interface. It has an address, write data, read data and separate read and write strobes. The pins are divided into two power banks. Pins whose global number is below `RESUME_BASE` belong to the core bank. The remaining pins belong to the resume bank, which numbers them again from zero.

Each bank has three register groups, each one bit per pin. Enable hands a pin over to GPIO use. Direction selects input or output. Level holds the value driven out, or reports what the pin reads.

A pin drives its output buffer only when it is both enabled and configured as an output. A level bit cannot be changed while its pin is an input. For that reason, a pin that is turned into an output first drives whatever level it last held, until software writes a new one. Pin inputs pass through a two-flop synchroniser before they appear in the level readback.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Address map. `addr_i[5]` selects the bank (0 = core at 0x00, 1 = resume at 0x20). `addr_i[3:2]` selects the group: 0 = enable (offset 0x00), 1 = direction (0x04), 2 = level (0x08). `addr_i[1:0]` is the byte index. A pin with in-bank index k sits in byte k/8 at bit k%8. A global pin g ≥ RESUME_BASE has in-bank index g − RESUME_BASE.
- R2: After reset, every direction bit is 1 and every level bit is 0. Enable bits are 1 for core pins below CORE_EN_RST and for resume pins below RES_EN_RST, and 0 for all others. `pin_oe_o` and `pin_o` are all zero.
- R3: A direction bit of 1 makes the pin an input, and 0 makes it an output. `pin_oe_o[g]` is 1 exactly when the enable bit of g is 1 and its direction bit is 0.
- R4: A write to a level bit is ignored when that pin's direction bit is 1 at the time of the write.
- R5: Reading a level bit returns the synchronised pin input when the pin is an input. A change on `pin_i` first appears in the read data two clock edges later. For an output pin, the read returns the stored level.
- R6: `pin_o[g]` always equals the stored level bit. A pin switched from input to output therefore drives its previously stored level. The level changes only through a level write.
- R7: Bits for in-bank indices at or beyond the bank's pin count read as 0, and writes to them are ignored. Addresses with `addr_i[4]` set, or with group 3, read 0x00.
- R8: `rdata_o` is 0x00 while `rd_i` is low. While `rd_i` is high, `rdata_o` is a combinational function of `addr_i`.
- R9: A write takes effect on the rising clock edge where `wr_i` is high, and is visible in the read data straight after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Register byte address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data |
| pin_i | input | NUM_PINS | Pad input values |
| pin_o | output | NUM_PINS | Pad output values |
| pin_oe_o | output | NUM_PINS | Pad output enables |

## Verification
The assertions check four things on every cycle:
- read data is zero when no read is strobed or the address is unmapped;
- pad levels move only after a write to a level address;
- output enables move only after some write.

Other behaviours can only be shown by the bench's scenarios, where a reference model tracks every register bit:
- whether a level write was dropped because the pin was an input;
- the two-cycle input latency;
- the held level appearing when a pin turns into an output;
- the exact bit placement across both banks.

The bench sweeps writes over all 64 addresses with two data and pin patterns, and re-reads the whole map after each write.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W        = 6;
  localparam int DATA_W        = 8;
  localparam int MAX_BANK_PINS = 32;

  typedef enum logic [1:0] {
    GRP_EN   = 2'd0,
    GRP_DIR  = 2'd1,
    GRP_LVL  = 2'd2,
    GRP_NONE = 2'd3
  } grp_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_port_pkg::*;
#(
  parameter int PINS       = 8,
  parameter int EN_RST_CNT = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  grp_e                grp_i,
  input  logic [1:0]          byte_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [PINS-1:0]     pin_sync_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [PINS-1:0]     en_o,
  output logic [PINS-1:0]     dir_o,
  output logic [PINS-1:0]     lvl_o
);
  logic [PINS-1:0] en_q, dir_q, lvl_q, lvl_rd;
  logic [MAX_BANK_PINS-1:0] en_pad, dir_pad, lvl_pad;

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    localparam int BYTE_IDX = p / 8;
    localparam int BIT_IDX  = p % 8;
    localparam logic EN_RST = (p < EN_RST_CNT);
    logic hit;
    assign hit = wr_i && (byte_i == 2'(BYTE_IDX));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q[p] <= EN_RST;
      else if (hit && grp_i == GRP_EN) en_q[p] <= wdata_i[BIT_IDX];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dir_q[p] <= 1'b1;
      else if (hit && grp_i == GRP_DIR) dir_q[p] <= wdata_i[BIT_IDX];
    end

    // level is read-only while the pin is an input
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q[p] <= 1'b0;
      else if (hit && grp_i == GRP_LVL && !dir_q[p]) lvl_q[p] <= wdata_i[BIT_IDX];
    end

    assign lvl_rd[p] = dir_q[p] ? pin_sync_i[p] : lvl_q[p];
  end

  assign en_pad  = MAX_BANK_PINS'(en_q);
  assign dir_pad = MAX_BANK_PINS'(dir_q);
  assign lvl_pad = MAX_BANK_PINS'(lvl_rd);

  always_comb begin
    unique case (grp_i)
      GRP_EN:  rdata_o = en_pad[byte_i*8 +: 8];
      GRP_DIR: rdata_o = dir_pad[byte_i*8 +: 8];
      GRP_LVL: rdata_o = lvl_pad[byte_i*8 +: 8];
      default: rdata_o = '0;
    endcase
  end

  assign en_o  = en_q;
  assign dir_o = dir_q;
  assign lvl_o = lvl_q;
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS    = 14,
  parameter int RESUME_BASE = 10,
  parameter int CORE_EN_RST = 7,
  parameter int RES_EN_RST  = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                wr_i,
  input  logic                rd_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o
);
  localparam int CORE_PINS = RESUME_BASE;
  localparam int RES_PINS  = NUM_PINS - RESUME_BASE;

  logic       bank_sel, hole;
  grp_e       grp;
  logic [1:0] byte_idx;
  logic       core_wr, res_wr;
  logic [DATA_W-1:0] core_rd, res_rd;
  logic [NUM_PINS-1:0] pin_sync;
  logic [CORE_PINS-1:0] core_en, core_dir, core_lvl;
  logic [RES_PINS-1:0]  res_en, res_dir, res_lvl;

  assign bank_sel = addr_i[5];
  assign hole     = addr_i[4];
  assign grp      = grp_e'(addr_i[3:2]);
  assign byte_idx = addr_i[1:0];
  assign core_wr  = wr_i && !hole && !bank_sel;
  assign res_wr   = wr_i && !hole && bank_sel;

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  gpio_bank #(.PINS(CORE_PINS), .EN_RST_CNT(CORE_EN_RST)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (core_wr),
    .grp_i     (grp),
    .byte_i    (byte_idx),
    .wdata_i   (wdata_i),
    .pin_sync_i(pin_sync[CORE_PINS-1:0]),
    .rdata_o   (core_rd),
    .en_o      (core_en),
    .dir_o     (core_dir),
    .lvl_o     (core_lvl)
  );

  gpio_bank #(.PINS(RES_PINS), .EN_RST_CNT(RES_EN_RST)) u_res (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (res_wr),
    .grp_i     (grp),
    .byte_i    (byte_idx),
    .wdata_i   (wdata_i),
    .pin_sync_i(pin_sync[NUM_PINS-1:CORE_PINS]),
    .rdata_o   (res_rd),
    .en_o      (res_en),
    .dir_o     (res_dir),
    .lvl_o     (res_lvl)
  );

  always_comb begin
    if (!rd_i || hole) rdata_o = '0;
    else               rdata_o = bank_sel ? res_rd : core_rd;
  end

  assign pin_o    = {res_lvl, core_lvl};
  assign pin_oe_o = {res_en & ~res_dir, core_en & ~core_dir};
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int NUM_PINS = 14
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [5:0]          addr_i,
  input logic                wr_i,
  input logic                rd_i,
  input logic [7:0]          rdata_o,
  input logic [NUM_PINS-1:0] pin_o,
  input logic [NUM_PINS-1:0] pin_oe_o
);
  AST_RDATA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == 8'h00); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (addr_i[4] || addr_i[3:2] == 2'b11)) |-> rdata_o == 8'h00); // R7

  AST_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i[4:2] == 3'b010) |=> $stable(pin_o)); // R6

  AST_OE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(pin_oe_o)); // R3
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .rdata_o (rdata_o),
  .pin_o   (pin_o),
  .pin_oe_o(pin_oe_o)
);

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;
  localparam int N  = 14;
  localparam int RB = 10;
  localparam int CE = 7;
  localparam int RE = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [5:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] rdata_o;
  logic [N-1:0] pin_i = '0;
  logic [N-1:0] pin_o, pin_oe_o;

  int n_chk = 0, n_bad = 0;
  bit [N-1:0] m_en, m_dir, m_lvl;

  always #2.5 clk_i = ~clk_i;

  gpio_port_ctrl #(.NUM_PINS(N), .RESUME_BASE(RB), .CORE_EN_RST(CE), .RES_EN_RST(RE)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_read(logic [5:0] a);
    int r = 0;
    int base = a[5] ? RB : 0;
    int cnt  = a[5] ? N - RB : RB;
    if (a[4] || a[3:2] == 2'b11) return 0;
    for (int j = 0; j < 8; j++) begin
      int idx = int'(a[1:0]) * 8 + j;
      if (idx < cnt) begin
        int g = base + idx;
        bit b;
        case (a[3:2])
          2'd0: b = m_en[g];
          2'd1: b = m_dir[g];
          default: b = m_dir[g] ? pin_i[g] : m_lvl[g];
        endcase
        if (b) r |= (1 << j);
      end
    end
    return r;
  endfunction

  function automatic void model_write(logic [5:0] a, logic [7:0] d);
    int base = a[5] ? RB : 0;
    int cnt  = a[5] ? N - RB : RB;
    if (a[4] || a[3:2] == 2'b11) return;
    for (int j = 0; j < 8; j++) begin
      int idx = int'(a[1:0]) * 8 + j;
      if (idx < cnt) begin
        int g = base + idx;
        case (a[3:2])
          2'd0: m_en[g] = d[j];
          2'd1: m_dir[g] = d[j];
          default: if (!m_dir[g]) m_lvl[g] = d[j];
        endcase
      end
    end
  endfunction

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(logic [5:0] a, output logic [7:0] v);
    addr_i = a; rd_i = 1'b1;
    #1 v = rdata_o;
    rd_i = 1'b0;
  endtask

  function automatic string tag_of(logic [5:0] a);
    if (a[4] || a[3:2] == 2'b11) return "R7";
    case (a[3:2])
      2'd0: return "R1";
      2'd1: return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic sweep_all(string force_tag);
    logic [7:0] v;
    for (int a = 0; a < 64; a++) begin
      rd(6'(a), v);
      check(force_tag == "" ? tag_of(6'(a)) : force_tag, v, exp_read(6'(a)));
    end
    check(force_tag == "" ? "R3" : force_tag, pin_oe_o, m_en & ~m_dir);
    check(force_tag == "" ? "R6" : force_tag, pin_o, m_lvl);
  endtask

  initial begin
    logic [7:0] v;
    m_dir = '1; m_lvl = '0; m_en = '0;
    for (int g = 0; g < N; g++)
      m_en[g] = (g < RB) ? (g < CE) : ((g - RB) < RE);
    pin_i = 14'h1A5;
    #12 rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R2 reset state across the whole map
    sweep_all("R2");
    check("R2", pin_oe_o, 0);

    // R8 read strobe low
    addr_i = 6'h08; rd_i = 1'b0; #1 check("R8", rdata_o, 0);

    // R6/R4 directed on core pin 2
    wr(6'h04, 8'hFB);
    wr(6'h08, 8'h04);
    check("R6", pin_o[2], 1);
    check("R3", pin_oe_o[2], 1);
    wr(6'h04, 8'hFF);
    check("R3", pin_oe_o[2], 0);
    wr(6'h08, 8'h00);                   // ignored: pin is an input
    check("R4", pin_o[2], 1);
    rd(6'h08, v); check("R5", v, exp_read(6'h08));
    wr(6'h04, 8'hFB);
    check("R6", pin_o[2], 1);
    rd(6'h08, v); check("R4", v[2], 1);

    // R7 resume bank beyond its 4 pins
    wr(6'h21, 8'hFF);
    rd(6'h21, v); check("R7", v, 0);
    wr(6'h20, 8'hFF);
    rd(6'h20, v); check("R7", v, 8'h0F);
    rd(6'h30, v); check("R7", v, 0);

    // R5 two-edge input latency on pin 0 (input)
    wr(6'h04, 8'hFF);
    pin_i[0] = 1'b0;
    repeat (3) @(negedge clk_i);
    pin_i[0] = 1'b1;
    @(negedge clk_i); rd(6'h08, v); check("R5", v[0], 0);
    @(negedge clk_i); rd(6'h08, v); check("R5", v[0], 1);

    // exhaustive write sweeps with full readback
    for (int ph = 0; ph < 2; ph++) begin
      pin_i = (ph == 0) ? 14'h2A5C : 14'h15A3;
      repeat (3) @(negedge clk_i);
      for (int a = 0; a < 64; a++) begin
        logic [7:0] d;
        d = 8'((a * 29 + ph * 101 + 7) & 8'hFF);
        wr(6'(a), d);
        rd(6'(a), v); check("R9", v, exp_read(6'(a)));
        sweep_all("");
      end
    end

    summary();
    $finish;
  end
endmodule